// File: doc/BRIEF.md
# Six-Channel Multi-Mode Sample FIFO

This block holds sample sets from a motion sensor: three rotation-rate axes and three linear-acceleration axes. Each data-ready strobe writes all six 16-bit channel values as one entry. The buffer has 32 entries. A host drains it one entry at a time. The oldest stored entry is always visible on the read data port, and a read strobe removes it.

A 3-bit mode input selects how the buffer behaves:

- It can be held empty.
- It can fill and then stop.
- It can keep overwriting its oldest entry.
- It can start in one behaviour and move to another when a trigger input pulses. Two such trigger-switched modes exist.

The block reports:

- the number of unread entries;
- a threshold flag, set when that number reaches a programmable level;
- a sticky overrun flag.

An interrupt line combines the threshold flag and the overrun flag, each through its own enable.

Top module: `sixch_sample_fifo`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `full`, `ovr_flag` and `irq` are 0.
- R2: Mode codes are 000 hold-empty, 001 fill-and-stop, 110 overwrite, 011 overwrite-then-stop, 100 hold-empty-then-overwrite. Codes 010, 101 and 111 behave as 000. In a hold-empty behaviour, writes are ignored and the count stays 0.
- R3: Under fill-and-stop, writes are stored until 32 entries are held. Further writes without a read are dropped, the stored data is unchanged and `ovr_flag` is not set.
- R4: Under overwrite, a write into a full buffer without a read discards the oldest entry. The count stays 32 and `ovr_flag` becomes 1.
- R5: Mode 011 behaves as overwrite until `trig` is sampled high, and as fill-and-stop from the following cycle.
- R6: Mode 100 behaves as hold-empty until `trig` is sampled high, and as overwrite from the following cycle. A mode change clears any trigger seen earlier.
- R7: Each cycle spent in a hold-empty behaviour empties the buffer and clears `ovr_flag`. Nothing else, including reads, clears `ovr_flag`.
- R8: `rd_data` shows the oldest entry, with channel c in bits [16c+15:16c]. `rd_stb` while non-empty removes that entry. `rd_stb` while empty has no effect.
- R9: `thr_flag` is 1 exactly when the count is greater than or equal to `thr_level`.
- R10: `irq` is 1 when (`thr_irq_en` and `thr_flag`) or (`ovr_irq_en` and `ovr_flag`).
- R11: A write and a read together on a full buffer, outside hold-empty, are both accepted. The count stays 32 and `ovr_flag` is not set by them.
- R12: The count never exceeds 32, and `full` is 1 exactly at 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 3 | Buffer behaviour select |
| trig | input | 1 | Event trigger for the switching modes |
| wr_stb | input | 1 | Data-ready strobe, writes one entry |
| wr_data | input | 96 | Six 16-bit channel samples |
| rd_stb | input | 1 | Removes the oldest entry |
| rd_data | output | 96 | Oldest entry, six channels |
| thr_level | input | 6 | Threshold level for `thr_flag` |
| thr_irq_en | input | 1 | Threshold interrupt enable |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| count | output | 6 | Unread entries |
| empty | output | 1 | Count is 0 |
| full | output | 1 | Count is 32 |
| thr_flag | output | 1 | Count at or above threshold |
| ovr_flag | output | 1 | Sticky overrun |
| irq | output | 1 | Enabled flags combined |

## Verification
The hardest situation to reach from the ports is the overwrite-then-stop mode after its switch. Getting there needs several steps in order. The buffer must first be overfilled under overwrite so that overrun is set and the head has moved. The trigger must then pulse. After that, writes into the still-full buffer must be shown to be dropped, while a single read reopens exactly one slot. The stimulus sends forty writes, then the trigger, then further writes, a read and one more write. It then drains the buffer and checks the order of what comes out against a sequence-tagged data pattern.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [1:0] {ACT_HOLD = 2'd0, ACT_STOP = 2'd1, ACT_WRAP = 2'd2} act_e;

  localparam logic [2:0] MC_HOLD      = 3'b000;
  localparam logic [2:0] MC_STOP      = 3'b001;
  localparam logic [2:0] MC_WRAP2STOP = 3'b011;
  localparam logic [2:0] MC_HOLD2WRAP = 3'b100;
  localparam logic [2:0] MC_WRAP      = 3'b110;

  function automatic act_e decode_act(logic [2:0] code, logic trig_eff);
    case (code)
      MC_STOP:      return ACT_STOP;
      MC_WRAP:      return ACT_WRAP;
      MC_WRAP2STOP: return trig_eff ? ACT_STOP : ACT_WRAP;
      MC_HOLD2WRAP: return trig_eff ? ACT_WRAP : ACT_HOLD;
      default:      return ACT_HOLD;
    endcase
  endfunction

  function automatic int unsigned ptr_wrap(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned count_next(int unsigned c, logic add, logic sub);
    return c + (add ? 1 : 0) - (sub ? 1 : 0);
  endfunction
endpackage

// File: rtl/sfifo_mode_ctrl.sv
module sfifo_mode_ctrl
  import sfifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_code,
  input  logic       trig,
  output act_e       act
);
  logic [2:0] mode_q;
  logic       trig_seen;
  logic       mode_chg;
  logic       trig_eff;

  assign mode_chg = (mode_code != mode_q);
  assign trig_eff = trig_seen & ~mode_chg;
  assign act      = decode_act(mode_code, trig_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MC_HOLD;
      trig_seen <= 1'b0;
    end else begin
      mode_q    <= mode_code;
      trig_seen <= mode_chg ? 1'b0 : (trig_seen | trig);
    end
  end
endmodule

// File: rtl/sfifo_lane.sv
module sfifo_lane #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_ptr_ctrl.sv
module sfifo_ptr_ctrl
  import sfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  act_e          act,
  input  logic          wr_stb,
  input  logic          rd_stb,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          ovr_flag,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          overwrite
);
  logic hold_now, at_full, has_room;

  assign hold_now  = (act == ACT_HOLD);
  assign at_full   = (count == CW'(DEPTH));
  assign pop_ok    = ~hold_now & rd_stb & (count != '0);
  assign has_room  = ~at_full | pop_ok;
  assign push_ok   = ~hold_now & wr_stb & (has_room | (act == ACT_WRAP));
  assign overwrite = push_ok & ~has_room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      ovr_flag <= 1'b0;
    end else if (hold_now) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      ovr_flag <= 1'b0;
    end else begin
      if (push_ok) wptr <= AW'(ptr_wrap(int'(wptr), DEPTH));
      if (pop_ok | overwrite) rptr <= AW'(ptr_wrap(int'(rptr), DEPTH));
      count <= CW'(count_next(int'(count), push_ok, pop_ok | overwrite));
      if (overwrite) ovr_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/sixch_sample_fifo.sv
module sixch_sample_fifo
  import sfifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NCH   = 6,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_code,
  input  logic              trig,
  input  logic              wr_stb,
  input  logic [NCH*DW-1:0] wr_data,
  input  logic              rd_stb,
  output logic [NCH*DW-1:0] rd_data,
  input  logic [CW-1:0]     thr_level,
  input  logic              thr_irq_en,
  input  logic              ovr_irq_en,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              full,
  output logic              thr_flag,
  output logic              ovr_flag,
  output logic              irq
);
  act_e          act;
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok, overwrite;
  logic          act_hold, act_stop, act_wrap;

  assign act_hold = (act == ACT_HOLD);
  assign act_stop = (act == ACT_STOP);
  assign act_wrap = (act == ACT_WRAP);

  sfifo_mode_ctrl mode_i (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .trig(trig), .act(act)
  );

  sfifo_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .act(act), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wptr(wptr), .rptr(rptr), .count(count), .ovr_flag(ovr_flag),
    .push_ok(push_ok), .pop_ok(pop_ok), .overwrite(overwrite)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    sfifo_lane #(.DW(DW), .DEPTH(DEPTH)) lane_i (
      .clk(clk), .we(push_ok), .waddr(wptr),
      .wdata(wr_data[c*DW +: DW]), .raddr(rptr),
      .rdata(rd_data[c*DW +: DW])
    );
  end

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign thr_flag = (count >= thr_level);
  assign irq      = (thr_irq_en & thr_flag) | (ovr_irq_en & ovr_flag);
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_stb,
  input logic          rd_stb,
  input logic [CW-1:0] count,
  input logic          ovr_flag,
  input logic          act_hold,
  input logic          act_stop,
  input logic          act_wrap,
  input logic          overwrite
);
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_hold_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_hold |=> (count == '0) && !ovr_flag);

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !act_hold) |=> ovr_flag);

  p_stop_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_stop && wr_stb && !rd_stb && count == CW'(DEPTH))
      |=> (count == CW'(DEPTH)) && $stable(ovr_flag));

  p_wrap_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_wrap && overwrite) |=> ovr_flag && (count == CW'(DEPTH)));

  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && count == '0) |=> (count == '0));

  p_both_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && rd_stb && !act_hold && count == CW'(DEPTH))
      |=> (count == CW'(DEPTH)) && $stable(ovr_flag));
endmodule

bind sixch_sample_fifo sfifo_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .count(count), .ovr_flag(ovr_flag), .act_hold(act_hold),
  .act_stop(act_stop), .act_wrap(act_wrap), .overwrite(overwrite)
);

// File: tb/sixch_sample_fifo_tb.sv
module sixch_sample_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_code = 3'b000;
  logic        trig = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [95:0] wr_data = '0;
  logic [95:0] rd_data;
  logic [5:0]  thr_level = 6'd32;
  logic        thr_irq_en = 1'b0, ovr_irq_en = 1'b0;
  logic [5:0]  count;
  logic        empty, full, thr_flag, ovr_flag, irq;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  sixch_sample_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .trig(trig),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .thr_level(thr_level), .thr_irq_en(thr_irq_en), .ovr_irq_en(ovr_irq_en),
    .count(count), .empty(empty), .full(full), .thr_flag(thr_flag),
    .ovr_flag(ovr_flag), .irq(irq)
  );

  function automatic logic [95:0] pat(int s);
    logic [95:0] v;
    for (int c = 0; c < 6; c++) v[c*16 +: 16] = {c[3:0], s[11:0]};
    return v;
  endfunction

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic w, logic r, int s, logic t = 1'b0);
    wr_stb = w; rd_stb = r; trig = t; wr_data = pat(s);
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; trig = 1'b0;
  endtask

  task automatic set_mode(logic [2:0] m);
    mode_code = m;
    step(1'b0, 1'b0, 0);
  endtask

  task automatic flush_to(logic [2:0] m);
    set_mode(3'b000);
    set_mode(m);
  endtask

  task automatic t_reset;
    chk("R1 count", 96'(count), 96'd0);
    chk("R1 empty", 96'(empty), 96'd1);
    chk("R1 full/ovr/irq", 96'({full, ovr_flag, irq}), 96'd0);
  endtask

  task automatic t_hold_codes;
    set_mode(3'b101);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, i);
    chk("R2 code 101 holds empty", 96'(count), 96'd0);
    set_mode(3'b000);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, i);
    chk("R2 code 000 holds empty", 96'({count, empty}), 96'd1);
  endtask

  task automatic t_stop_mode;
    flush_to(3'b001);
    for (int i = 0; i < 35; i++) step(1'b1, 1'b0, i);
    chk("R3 count at limit", 96'(count), 96'd32);
    chk("R12 full flag", 96'(full), 96'd1);
    chk("R3 no overrun", 96'(ovr_flag), 96'd0);
    for (int i = 0; i < 32; i++) begin
      if (rd_data !== pat(i)) chk("R3 R8 order", rd_data, pat(i));
      step(1'b0, 1'b1, 0);
    end
    chk("R8 drained", 96'(count), 96'd0);
  endtask

  task automatic t_wrap_mode;
    flush_to(3'b110);
    for (int i = 0; i < 34; i++) step(1'b1, 1'b0, i);
    chk("R4 count stays 32", 96'(count), 96'd32);
    chk("R4 overrun set", 96'(ovr_flag), 96'd1);
    chk("R4 oldest discarded", rd_data, pat(2));
  endtask

  task automatic t_flush;
    step(1'b0, 1'b1, 0);
    step(1'b0, 1'b1, 0);
    chk("R7 read leaves overrun", 96'(ovr_flag), 96'd1);
    chk("R8 head after reads", rd_data, pat(4));
    set_mode(3'b000);
    chk("R7 flush count", 96'(count), 96'd0);
    chk("R7 flush overrun", 96'(ovr_flag), 96'd0);
  endtask

  task automatic t_wrap2stop;
    flush_to(3'b011);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, i);
    chk("R5 wraps before trigger", 96'({count, ovr_flag}), 96'({6'd32, 1'b1}));
    chk("R5 head before trigger", rd_data, pat(8));
    step(1'b0, 1'b0, 0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 100 + i);
    chk("R5 drops after trigger", rd_data, pat(8));
    step(1'b0, 1'b1, 0);
    step(1'b1, 1'b0, 200);
    chk("R5 one slot reopened", 96'(count), 96'd32);
    for (int i = 0; i < 31; i++) step(1'b0, 1'b1, 0);
    chk("R5 last entry kept", rd_data, pat(200));
  endtask

  task automatic t_hold2wrap;
    flush_to(3'b100);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, i);
    chk("R6 holds before trigger", 96'(count), 96'd0);
    step(1'b0, 1'b0, 0, 1'b1);
    for (int i = 0; i < 34; i++) step(1'b1, 1'b0, i);
    chk("R6 wraps after trigger", 96'({count, ovr_flag}), 96'({6'd32, 1'b1}));
    chk("R6 head", rd_data, pat(2));
    set_mode(3'b011);
    set_mode(3'b100);
    step(1'b1, 1'b0, 0);
    chk("R6 trigger cleared by mode change", 96'(count), 96'd0);
  endtask

  task automatic t_thr_irq;
    flush_to(3'b001);
    thr_level = 6'd4; thr_irq_en = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, i);
    chk("R9 below threshold", 96'({thr_flag, irq}), 96'd0);
    step(1'b1, 1'b0, 3);
    chk("R9 R10 at threshold", 96'({thr_flag, irq}), 96'd3);
    thr_irq_en = 1'b0;
    #1;
    chk("R10 masked", 96'(irq), 96'd0);
    flush_to(3'b110);
    for (int i = 0; i < 33; i++) step(1'b1, 1'b0, i);
    chk("R10 overrun no enable", 96'(irq), 96'd0);
    ovr_irq_en = 1'b1;
    #1;
    chk("R10 overrun irq", 96'(irq), 96'd1);
    ovr_irq_en = 1'b0; thr_level = 6'd32;
  endtask

  task automatic t_both_full;
    flush_to(3'b110);
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, i);
    step(1'b1, 1'b1, 50);
    chk("R11 count", 96'(count), 96'd32);
    chk("R11 no overrun", 96'(ovr_flag), 96'd0);
    chk("R11 head", rd_data, pat(1));
  endtask

  task automatic t_empty_read;
    flush_to(3'b001);
    step(1'b0, 1'b1, 0);
    chk("R8 empty read", 96'(count), 96'd0);
    step(1'b1, 1'b0, 7);
    step(1'b0, 1'b1, 0);
    step(1'b0, 1'b1, 0);
    chk("R8 read past empty", 96'({count, empty}), 96'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    #1;
    t_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_codes();
    t_stop_mode();
    t_wrap_mode();
    t_flush();
    t_wrap2stop();
    t_hold2wrap();
    t_thr_irq();
    t_both_full();
    t_empty_read();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule